// File: doc/BRIEF.md
# Static Direction-Based Branch Predictor

This fetch-stage unit keeps the program counter. In each cycle it gives a taken or not-taken guess for the instruction being fetched, in that same cycle, and picks the next fetch address. The guess uses only the direction of the branch. When the sign bit of the branch's word offset is set, the target lies below the branch, so the branch is predicted taken and fetch moves to the target. A target above the branch is predicted not taken, and fetch continues at the next sequential word. The unit keeps no history.

The guess leaves on `pred_taken` and travels down the pipeline with the instruction. When a later stage resolves the branch, it returns the actual outcome, the guess that was carried and the correct continuation address. If the outcome and the guess disagree, the unit raises `squash` in that cycle so that the wrong-path instructions are dropped. The same cycle loads the correct address as the next fetch PC. This redirect takes priority over any guess made in that cycle.

Top module: `static_branch_guess`

## Requirements
- R1: While `rst_n` is low, and after it is released, `fetch_pc` holds `RESET_PC` until the first clock edge that follows the release.
- R2: The target is `fetch_pc + 4 + (sign-extended br_offset shifted left by 2)`, taken modulo 2^PC_W.
- R3: A fetched branch whose `br_offset` has its top bit set (a negative, backward offset) gives `pred_taken` = 1 in the same cycle, and `next_pc` equals the R2 target when no mispredict is reported.
- R4: A fetched branch whose `br_offset` has its top bit clear (a forward offset) gives `pred_taken` = 0, and `next_pc` = `fetch_pc + 4` when no mispredict is reported.
- R5: When `is_branch` = 0, `pred_taken` = 0 and `next_pc` = `fetch_pc + 4` whatever the value of `br_offset`, as long as no mispredict is reported.
- R6: A mispredict is a cycle with `res_valid` = 1 and `res_taken` != `res_pred`. In that cycle `squash` = 1 and `next_pc` = `res_target`, overriding the fetch-side guess.
- R7: A resolution that matches its guess (`res_valid` = 1 with `res_taken` == `res_pred`), or a cycle with `res_valid` = 0, leaves `squash` at 0 and has no effect on `next_pc`.
- R8: At each rising clock edge outside reset, `fetch_pc` takes the value `next_pc` had before that edge.
- R9: `squash` is high for exactly the cycles in which a mispredict is reported: one cycle for each mispredict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| is_branch | input | 1 | The instruction fetched at `fetch_pc` is a conditional branch |
| br_offset | input | OFF_W | Signed word offset of the fetched branch |
| res_valid | input | 1 | A branch resolution is being reported in this cycle |
| res_taken | input | 1 | Actual outcome of the resolved branch |
| res_pred | input | 1 | Guess that was carried with the resolved branch |
| res_target | input | PC_W | Correct continuation address of the resolved branch |
| fetch_pc | output | PC_W | Address being fetched in this cycle |
| pred_taken | output | 1 | Guess for the instruction being fetched, to travel with it |
| next_pc | output | PC_W | Address that will be fetched in the next cycle |
| squash | output | 1 | Cancel the wrong-path instructions (mispredict in this cycle) |

## Verification
The bench builds the unit with PC_W = 10 and OFF_W = 4. The 16 offset values, each with the branch flag both set and clear, are then swept many times while the PC moves through and wraps around a 1024-byte space, so R2 is checked both where the target wraps below zero and where it wraps past the top. Resolution reports arrive at a rate that is prime relative to the offset sweep. Every combination of actual outcome and carried guess therefore meets backward, forward and non-branch fetches in the same cycle, which tests the priority of the redirect.

// File: rtl/static_branch_guess.sv
module static_branch_guess #(
  parameter int PC_W = 32,
  parameter int OFF_W = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            is_branch,
  input  logic [OFF_W-1:0] br_offset,
  input  logic            res_valid,
  input  logic            res_taken,
  input  logic            res_pred,
  input  logic [PC_W-1:0] res_target,
  output logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc,
  output logic            squash
);
  localparam int EXT_W = PC_W - OFF_W - 2;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] seq_pc;
  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] br_target;

  assign seq_pc     = pc_q + PC_W'(4);
  assign disp       = {{EXT_W{br_offset[OFF_W-1]}}, br_offset, 2'b00};
  assign br_target  = seq_pc + disp;
  assign pred_taken = is_branch & br_offset[OFF_W-1];
  assign squash     = res_valid & (res_taken ^ res_pred);

  always_comb begin
    if (squash)
      next_pc = res_target;
    else if (pred_taken)
      next_pc = br_target;
    else
      next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      pc_q <= RESET_PC;
    else
      pc_q <= next_pc;
  end

  assign fetch_pc = pc_q;
endmodule

// File: rtl/static_branch_guess_chk.sv
module static_branch_guess_chk #(
  parameter int PC_W = 32,
  parameter int OFF_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            is_branch,
  input logic [OFF_W-1:0] br_offset,
  input logic            res_valid,
  input logic            res_taken,
  input logic            res_pred,
  input logic [PC_W-1:0] res_target,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic            squash
);
  logic [PC_W-1:0] chk_tgt;
  assign chk_tgt = PC_W'($signed(fetch_pc) + $signed(PC_W'(4)) +
                        ($signed({{(PC_W-OFF_W){br_offset[OFF_W-1]}}, br_offset}) <<< 2));

  p_backward_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && br_offset[OFF_W-1] && !squash) |=> (fetch_pc == $past(chk_tgt)));

  p_forward_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !br_offset[OFF_W-1] && !squash) |=> (fetch_pc == $past(fetch_pc) + PC_W'(4)));

  p_nonbranch_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_branch && !squash) |=> (fetch_pc == $past(fetch_pc) + PC_W'(4)));

  p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> (fetch_pc == $past(res_target)));

  p_guess_only_branch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> is_branch);

  p_squash_needs_res_r9: assert property (@(posedge clk) disable iff (!rst_n)
    squash |-> res_valid);

  p_match_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_taken == res_pred) |-> !squash);

  p_pc_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (fetch_pc == $past(next_pc)));
endmodule

bind static_branch_guess static_branch_guess_chk #(.PC_W(PC_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/static_branch_guess_test.sv
module static_branch_guess_test;
  localparam int PC_W = 10;
  localparam int OFF_W = 4;
  localparam int CLK_PERIOD = 10;
  localparam logic [PC_W-1:0] RST_PC = 10'h3F0;

  logic clk = 0;
  logic rst_n = 0;
  logic is_branch = 0;
  logic [OFF_W-1:0] br_offset = '0;
  logic res_valid = 0, res_taken = 0, res_pred = 0;
  logic [PC_W-1:0] res_target = '0;
  logic [PC_W-1:0] fetch_pc, next_pc;
  logic pred_taken, squash;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  static_branch_guess #(.PC_W(PC_W), .OFF_W(OFF_W), .RESET_PC(RST_PC)) uut (
    .clk(clk), .rst_n(rst_n), .is_branch(is_branch), .br_offset(br_offset),
    .res_valid(res_valid), .res_taken(res_taken), .res_pred(res_pred),
    .res_target(res_target), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
    .next_pc(next_pc), .squash(squash));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    int exp_pc;
    repeat (3) @(negedge clk);
    check("R1 reset hold", fetch_pc, RST_PC);
    rst_n = 1;
    #1 check("R1 after release", fetch_pc, RST_PC);
    exp_pc = RST_PC;
    for (int i = 0; i < 2000; i++) begin
      int off_i, tgt, exp_next, mis, exp_tk;
      is_branch  = (i % 3) != 0;
      br_offset  = OFF_W'((i ^ (i >> 4)) & 15);
      res_valid  = (i % 7) < 3;
      res_taken  = ((i / 7) & 1) != 0;
      res_pred   = ((i / 14) & 1) != 0;
      res_target = PC_W'((i * 52 + 8) & 1023);
      off_i  = br_offset[OFF_W-1] ? int'(br_offset) - 16 : int'(br_offset);
      tgt    = (exp_pc + 4 + off_i * 4) & 1023;
      mis    = (res_valid && (res_taken != res_pred)) ? 1 : 0;
      exp_tk = (is_branch && off_i < 0) ? 1 : 0;
      if (mis != 0) exp_next = res_target;
      else if (exp_tk != 0) exp_next = tgt;
      else exp_next = (exp_pc + 4) & 1023;
      #1;
      if (!is_branch) check("R5 non-branch guess", pred_taken, 0);
      else if (off_i < 0) check("R3 backward guess", pred_taken, 1);
      else check("R4 forward guess", pred_taken, 0);
      if (mis != 0) begin
        check("R6 redirect", next_pc, exp_next);
        check("R9 squash on mispredict", squash, 1);
      end else begin
        check("R7 squash quiet", squash, 0);
        if (exp_tk != 0) check("R2 R3 target", next_pc, exp_next);
        else if (is_branch) check("R4 sequential", next_pc, exp_next);
        else check("R5 sequential", next_pc, exp_next);
      end
      @(negedge clk);
      check("R8 pc load", fetch_pc, exp_next);
      exp_pc = exp_next;
    end
    rst_n = 0;
    res_valid = 0;
    @(negedge clk);
    check("R1 reset again", fetch_pc, RST_PC);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule